// File: doc/BRIEF.md
# External Peripheral Bus Read Sequencer

This block runs read cycles on an external generic peripheral bus for a single chip-select region. An internal requester gives a byte address, a beat count and a one-cycle start pulse. If the address falls inside the region, the block runs one bus beat per requested word. Each beat has three parts: an address latch phase, a programmable gap, and a strobe phase in which chip select and output enable are both driven. The block captures the word on the bus at the end of each strobe, reports it with a valid pulse, and raises a done pulse once the whole request has finished.

The timing of each phase comes from a configuration register. At reset this register is loaded from a 2-bit boot-mode strap, with phase lengths derived from nanosecond targets and the clock period. Software-side logic may later overwrite it through a write port. The bus can be multiplexed, with the address sent on the shared data lines during the latch phase, or non-multiplexed, with separate address lines. It can be 32 or 8 bits wide. A beat can end after a fixed count or when the external ready pin is seen high. An early chip-select option reshapes only the chip-select pin.

Top module: `xbus_seq`

## Requirements
- R1: While reset is high and afterwards until a request is accepted, `bus_ale`, `bus_cs`, `bus_oe`, `bus_ad_oe`, `busy`, `rd_valid` and `done` are all 0.
- R2: Reset defaults depend on `boot_mode`. The latch phase lasts ceil(40 ns / clock period) cycles (4 at 100 MHz). The strobe lasts ceil(240 ns / clock period) cycles (24). The gap lasts 1 cycle. There is no sample extension and no early chip select. Mode 00 gives 32-bit, multiplexed, fixed timing. Mode 01 gives 8-bit, non-multiplexed, fixed timing. Modes 10 and 11 give 32-bit, non-multiplexed, ready-terminated timing.
- R3: A start whose address lies outside [0x1FC0_0000, 0x2000_0000) is ignored. No strobe rises, `busy` stays 0, and neither `rd_valid` nor `done` pulses.
- R4: Each beat drives `bus_ale` for `cfg_ale_w` cycles. Then for `cfg_gap_w` cycles neither `bus_ale` nor `bus_oe` is high. Then the strobe phase follows, with `bus_cs` and `bus_oe` high. Without early chip select, `bus_cs` is never high together with `bus_ale`. A request of B beats keeps `busy` high for B × (latch + gap + strobe) + 1 cycles.
- R5: With `cfg_early` set, `bus_cs` is also high through the latch phase and the gap. `bus_oe` and `busy` keep exactly the timing they have without the option.
- R6: In fixed-timing mode (`cfg_ack` = 0) the strobe lasts `cfg_stb_w` + `cfg_smpl_w` cycles, whatever the level of `bus_rdy`.
- R7: In ready mode (`cfg_ack` = 1) the strobe lasts at least `cfg_stb_w` cycles. It continues until `bus_rdy` is sampled high at a rising edge, and then for `cfg_smpl_w` more cycles.
- R8: A nonzero `cfg_smpl_w` holds chip select and output enable for exactly that many extra cycles after the beat's termination condition is met.
- R9: On a multiplexed bus, `bus_ad_oe` is high exactly during the latch phase, and `bus_ad_out` then carries the beat address. Each later beat of a burst adds 4 to the address on a 32-bit bus, or 1 on an 8-bit bus.
- R10: On a non-multiplexed bus, `bus_addr` carries the request's start address on every beat of a burst and never changes while `busy` is high.
- R11: The word on `bus_ad_in` in the last strobe cycle of a beat appears on `rd_data`, with `rd_valid` high, in the next cycle. On an 8-bit bus only bits [7:0] are kept, zero-extended.
- R12: `done` is high for one cycle, in the cycle after the final beat's `rd_valid`, once per accepted request.
- R13: A cycle with `cfg_we` high replaces all timing and mode settings with the `cfg_*` inputs, and the next request uses them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 2 | Strap that selects the reset configuration |
| cfg_we | input | 1 | Load the configuration from the cfg_* inputs |
| cfg_ale_w | input | 6 | Latch phase length in cycles |
| cfg_gap_w | input | 6 | Cycles from latch end to strobe start |
| cfg_stb_w | input | 6 | Minimum strobe length in cycles |
| cfg_smpl_w | input | 6 | Strobe extension after termination |
| cfg_early | input | 1 | Early chip select on the pin |
| cfg_mux | input | 1 | Multiplexed address/data bus |
| cfg_ack | input | 1 | Terminate the strobe on ready |
| cfg_narrow | input | 1 | 8-bit bus when 1, 32-bit when 0 |
| req_start | input | 1 | One-cycle request pulse, taken only when idle |
| req_addr | input | 32 | Start byte address |
| req_beats | input | 4 | Beats in the request (0 is treated as 1) |
| bus_rdy | input | 1 | External ready |
| bus_ad_in | input | 32 | Data lines sampled from the bus |
| bus_ale | output | 1 | Address latch enable |
| bus_cs | output | 1 | Chip select pin, active high |
| bus_oe | output | 1 | Output enable, active high |
| bus_ad_out | output | 32 | Address driven on the shared lines |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_addr | output | 32 | Separate address lines (non-multiplexed) |
| busy | output | 1 | A request is in progress |
| rd_valid | output | 1 | rd_data holds a captured beat |
| rd_data | output | 32 | Captured word |
| done | output | 1 | Request complete |

## Verification
The assertions assume that configuration is written only while `busy` is low, so the mode seen by the address-hold and chip-select checks cannot change within a request. They also assume that `bus_rdy` is a synchronous input. The bench writes configuration only between requests and pulses `req_start` only when idle. It drives `bus_rdy` and the data lines at the falling edge from a small peripheral model. That model latches the multiplexed address during the latch phase and returns a pattern computed from the address it sees.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int CNT_W  = 6;
    localparam int BEAT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_GAP,
        ST_STB,
        ST_HOLD,
        ST_FIN
    } state_e;

    typedef struct packed {
        cnt_t ale_w;
        cnt_t gap_w;
        cnt_t stb_w;
        cnt_t smpl_w;
        logic early;
        logic mux;
        logic ack;
        logic narrow;
    } cfg_t;

    // Ceiling conversion of a duration to clock cycles, never below 1
    // and saturated to the counter range.
    function automatic cnt_t ps_to_cycles(input int unsigned dur_ps,
                                          input int unsigned clk_ps);
        int unsigned q;
        int unsigned lim;
        q   = (dur_ps + clk_ps - 1) / clk_ps;
        lim = (1 << CNT_W) - 1;
        if (q < 1)   q = 1;
        if (q > lim) q = lim;
        return cnt_t'(q);
    endfunction

    function automatic cnt_t load_val(input cnt_t v);
        return (v == '0) ? '0 : cnt_t'(v - 1'b1);
    endfunction

    function automatic cfg_t boot_cfg(input logic [1:0] mode,
                                      input cnt_t latch_cyc,
                                      input cnt_t access_cyc);
        cfg_t c;
        c.ale_w  = latch_cyc;
        c.gap_w  = cnt_t'(1);
        c.stb_w  = access_cyc;
        c.smpl_w = '0;
        c.early  = 1'b0;
        case (mode)
            2'b00:   begin c.mux = 1'b1; c.narrow = 1'b0; c.ack = 1'b0; end
            2'b01:   begin c.mux = 1'b0; c.narrow = 1'b1; c.ack = 1'b0; end
            default: begin c.mux = 1'b0; c.narrow = 1'b0; c.ack = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg
    import xbus_pkg::*;
#(
    parameter int unsigned CLK_PS    = 10000,
    parameter int unsigned LATCH_PS  = 40000,
    parameter int unsigned ACCESS_PS = 240000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] boot_mode,
    input  logic       we,
    input  cfg_t       wr,
    output cfg_t       cfg
);

    localparam cnt_t LATCH_CYC  = ps_to_cycles(LATCH_PS, CLK_PS);
    localparam cnt_t ACCESS_CYC = ps_to_cycles(ACCESS_PS, CLK_PS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= boot_cfg(boot_mode, LATCH_CYC, ACCESS_CYC);
        end else if (we) begin
            cfg <= wr;
        end
    end

endmodule

// File: rtl/xbus_ctl.sv
module xbus_ctl
    import xbus_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter logic [31:0] REGION_BASE  = 32'h1FC0_0000,
    parameter logic [31:0] REGION_BYTES = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              rdy,
    output state_e            st,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              beat_end
);

    localparam logic [ADDR_W:0] BASE_X  = (ADDR_W+1)'(REGION_BASE);
    localparam logic [ADDR_W:0] LIMIT_X = (ADDR_W+1)'(REGION_BASE) + (ADDR_W+1)'(REGION_BYTES);
    localparam int              WORD_B  = DATA_W / 8;

    cnt_t              cnt;
    logic [BEAT_W-1:0] beats_left;
    logic              hit;
    logic              stb_term;
    logic [ADDR_W-1:0] step;

    assign hit = ({1'b0, req_addr} >= BASE_X) && ({1'b0, req_addr} < LIMIT_X);

    // Condition that ends the minimum strobe: count spent and, in
    // ready mode, ready seen high at this edge.
    assign stb_term = (st == ST_STB) && (cnt == '0) && (!cfg.ack || rdy);

    assign beat_end = (stb_term && (cfg.smpl_w == '0)) ||
                      ((st == ST_HOLD) && (cnt == '0));

    assign step = cfg.mux ? (cfg.narrow ? ADDR_W'(1) : ADDR_W'(WORD_B)) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            cur_addr   <= '0;
            beats_left <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_start && hit) begin
                        cur_addr   <= req_addr;
                        beats_left <= (req_beats == '0) ? BEAT_W'(1) : req_beats;
                        cnt        <= load_val(cfg.ale_w);
                        st         <= ST_ALE;
                    end
                end
                ST_ALE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (cfg.gap_w == '0) begin
                        cnt <= load_val(cfg.stb_w);
                        st  <= ST_STB;
                    end else begin
                        cnt <= load_val(cfg.gap_w);
                        st  <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        cnt <= load_val(cfg.stb_w);
                        st  <= ST_STB;
                    end
                end
                ST_STB, ST_HOLD: begin
                    if (beat_end) begin
                        if (beats_left == BEAT_W'(1)) begin
                            st <= ST_FIN;
                        end else begin
                            beats_left <= beats_left - 1'b1;
                            cur_addr   <= cur_addr + step;
                            cnt        <= load_val(cfg.ale_w);
                            st         <= ST_ALE;
                        end
                    end else if (stb_term) begin
                        cnt <= load_val(cfg.smpl_w);
                        st  <= ST_HOLD;
                    end else if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_FIN: begin
                    st <= ST_IDLE;
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    AST_ACK_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STB && cnt == '0 && cfg.ack && !rdy) |=> (st == ST_STB)); // R7

    AST_IDLE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && req_start && !hit) |=> (st == ST_IDLE)); // R3

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  state_e            st,
    input  cfg_t              cfg,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              beat_end,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ale,
    output logic              bus_cs,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    logic strobe;
    logic addr_phase;

    assign busy       = (st != ST_IDLE);
    assign strobe     = (st == ST_STB) || (st == ST_HOLD);
    assign addr_phase = (st == ST_ALE) || (st == ST_GAP);

    assign bus_ale    = (st == ST_ALE);
    assign bus_oe     = strobe;
    assign bus_cs     = strobe || (cfg.early && addr_phase);
    assign bus_ad_oe  = cfg.mux && (st == ST_ALE);
    assign bus_ad_out = bus_ad_oe ? DATA_W'(cur_addr) : '0;
    assign bus_addr   = (!cfg.mux && busy) ? cur_addr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            rd_valid <= beat_end;
            done     <= (st == ST_FIN);
            if (beat_end) begin
                rd_data <= cfg.narrow ? DATA_W'(bus_ad_in[7:0]) : bus_ad_in;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_ale && !bus_cs && !bus_oe)); // R1

    AST_NO_CS_WITH_ALE: assert property (@(posedge clk) disable iff (rst)
        (!cfg.early && bus_ale) |-> !bus_cs); // R4

    AST_VALID_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bus_oe)); // R11

    AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(rd_valid) && !rd_valid)); // R12

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int unsigned CLK_PS       = 10000,
    parameter int unsigned LATCH_PS     = 40000,
    parameter int unsigned ACCESS_PS    = 240000,
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter logic [31:0] REGION_BASE  = 32'h1FC0_0000,
    parameter logic [31:0] REGION_BYTES = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        boot_mode,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_ale_w,
    input  logic [CNT_W-1:0]  cfg_gap_w,
    input  logic [CNT_W-1:0]  cfg_stb_w,
    input  logic [CNT_W-1:0]  cfg_smpl_w,
    input  logic              cfg_early,
    input  logic              cfg_mux,
    input  logic              cfg_ack,
    input  logic              cfg_narrow,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ale,
    output logic              bus_cs,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    cfg_t              cfg_wr;
    cfg_t              cfg;
    state_e            st;
    logic [ADDR_W-1:0] cur_addr;
    logic              beat_end;

    always_comb begin
        cfg_wr.ale_w  = cfg_ale_w;
        cfg_wr.gap_w  = cfg_gap_w;
        cfg_wr.stb_w  = cfg_stb_w;
        cfg_wr.smpl_w = cfg_smpl_w;
        cfg_wr.early  = cfg_early;
        cfg_wr.mux    = cfg_mux;
        cfg_wr.ack    = cfg_ack;
        cfg_wr.narrow = cfg_narrow;
    end

    xbus_cfg #(
        .CLK_PS   (CLK_PS),
        .LATCH_PS (LATCH_PS),
        .ACCESS_PS(ACCESS_PS)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .boot_mode(boot_mode),
        .we       (cfg_we),
        .wr       (cfg_wr),
        .cfg      (cfg)
    );

    xbus_ctl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .REGION_BASE (REGION_BASE),
        .REGION_BYTES(REGION_BYTES)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .req_start(req_start),
        .req_addr (req_addr),
        .req_beats(req_beats),
        .rdy      (bus_rdy),
        .st       (st),
        .cur_addr (cur_addr),
        .beat_end (beat_end)
    );

    xbus_pins #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .cfg       (cfg),
        .cur_addr  (cur_addr),
        .beat_end  (beat_end),
        .bus_ad_in (bus_ad_in),
        .bus_ale   (bus_ale),
        .bus_cs    (bus_cs),
        .bus_oe    (bus_oe),
        .bus_ad_out(bus_ad_out),
        .bus_ad_oe (bus_ad_oe),
        .bus_addr  (bus_addr),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .done      (done)
    );

    AST_NONMUX_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !cfg.mux && !$past(cfg_we)) |-> $stable(bus_addr)); // R10

    AST_EARLY_CS_WITH_ALE: assert property (@(posedge clk) disable iff (rst)
        (cfg.early && bus_ale) |-> bus_cs); // R5

endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  boot_mode = 2'b00;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_ale_w = '0, cfg_gap_w = '0, cfg_stb_w = '0, cfg_smpl_w = '0;
    logic        cfg_early = 1'b0, cfg_mux = 1'b0, cfg_ack = 1'b0, cfg_narrow = 1'b0;
    logic        req_start = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_beats = '0;
    logic        bus_rdy = 1'b0;
    logic [31:0] bus_ad_in;
    logic        bus_ale, bus_cs, bus_oe, bus_ad_oe, busy, rd_valid, done;
    logic [31:0] bus_ad_out, bus_addr, rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // peripheral model state
    logic        model_mux = 1'b1;
    logic [31:0] lat_addr  = '0;
    int          rdy_mode  = 0;   // 0 low, 1 high, 2 after rdy_dly strobe cycles
    int          rdy_dly   = 1;
    int          oe_run    = 0;

    // measurement counters
    int n_ale, n_cs, n_oe, n_busy, n_overlap, n_adoe, n_valid, n_done;

    logic [31:0] exp_q[$];

    xbus_seq dut (
        .clk(clk), .rst(rst), .boot_mode(boot_mode), .cfg_we(cfg_we),
        .cfg_ale_w(cfg_ale_w), .cfg_gap_w(cfg_gap_w), .cfg_stb_w(cfg_stb_w),
        .cfg_smpl_w(cfg_smpl_w), .cfg_early(cfg_early), .cfg_mux(cfg_mux),
        .cfg_ack(cfg_ack), .cfg_narrow(cfg_narrow), .req_start(req_start),
        .req_addr(req_addr), .req_beats(req_beats), .bus_rdy(bus_rdy),
        .bus_ad_in(bus_ad_in), .bus_ale(bus_ale), .bus_cs(bus_cs),
        .bus_oe(bus_oe), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_addr(bus_addr), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    assign bus_ad_in = pat(model_mux ? lat_addr : bus_addr);

    task automatic check_eq(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic clear_meas();
        n_ale = 0; n_cs = 0; n_oe = 0; n_busy = 0;
        n_overlap = 0; n_adoe = 0; n_valid = 0; n_done = 0;
    endtask

    // peripheral model, measurement and scoreboard monitor
    always @(negedge clk) begin
        cycles++;
        if (bus_ale) lat_addr = bus_ad_out;
        if (bus_oe) oe_run++; else oe_run = 0;
        case (rdy_mode)
            0:       bus_rdy = 1'b0;
            1:       bus_rdy = 1'b1;
            default: bus_rdy = (oe_run >= rdy_dly);
        endcase
        if (!rst) begin
            if (bus_ale) n_ale++;
            if (bus_cs) n_cs++;
            if (bus_oe) n_oe++;
            if (busy) n_busy++;
            if (bus_ale && bus_cs) n_overlap++;
            if (bus_ad_oe) n_adoe++;
            if (done) n_done++;
            if (rd_valid) begin
                n_valid++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R11: got %08h expected no data", rd_data);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    if (rd_data !== e) begin
                        errors++;
                        $display("FAIL R11: got %08h expected %08h", rd_data, e);
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk);
        boot_mode = mode;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input int aw, input int gw, input int sw, input int rs,
                             input logic early, input logic mux, input logic ack,
                             input logic narrow);
        @(negedge clk);
        cfg_ale_w = 6'(aw); cfg_gap_w = 6'(gw); cfg_stb_w = 6'(sw); cfg_smpl_w = 6'(rs);
        cfg_early = early; cfg_mux = mux; cfg_ack = ack; cfg_narrow = narrow;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: pushes the expected words, then issues the request
    task automatic do_read(input logic [31:0] addr, input int beats, input int inc,
                           input logic narrow);
        for (int i = 0; i < beats; i++) begin
            logic [31:0] w;
            w = pat(addr + 32'(i * inc));
            exp_q.push_back(narrow ? {24'h0, w[7:0]} : w);
        end
        clear_meas();
        @(negedge clk);
        req_addr = addr; req_beats = 4'(beats); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        while (n_done == 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        do_reset(2'b00);
        check_eq("R1 ale", int'(bus_ale), 0);
        check_eq("R1 cs", int'(bus_cs), 0);
        check_eq("R1 oe", int'(bus_oe), 0);
        check_eq("R1 busy/valid/done", int'(busy | rd_valid | done | bus_ad_oe), 0);

        // R2: boot mode 00 defaults, multiplexed 32-bit fixed
        model_mux = 1'b1; rdy_mode = 0;
        do_read(32'h1FC0_0010, 1, 4, 1'b0);
        check_eq("R2 latch cycles", n_ale, 4);
        check_eq("R2 strobe cycles", n_oe, 24);
        check_eq("R4 busy cycles default", n_busy, 30);
        check_eq("R9 ad_oe only in latch", n_adoe, 4);
        check_eq("R12 done count", n_done, 1);

        // R3: outside the window, including the first address past the end
        clear_meas();
        @(negedge clk); req_addr = 32'h2000_0000; req_beats = 4'd1; req_start = 1'b1;
        @(negedge clk); req_addr = 32'h0000_0100;
        @(negedge clk); req_addr = 32'h1FBF_FFFC;
        @(negedge clk); req_start = 1'b0;
        repeat (20) @(negedge clk);
        check_eq("R3 busy", n_busy, 0);
        check_eq("R3 cs", n_cs, 0);
        check_eq("R3 valid+done", n_valid + n_done, 0);

        // R13 R4 R9: new config, multiplexed 32-bit burst of 4
        write_cfg(2, 3, 4, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        do_read(32'h1FFF_FFF0, 4, 4, 1'b0);
        check_eq("R13 latch cycles", n_ale, 8);
        check_eq("R4 strobe cycles", n_oe, 16);
        check_eq("R4 busy cycles", n_busy, 37);
        check_eq("R4 no cs with ale", n_overlap, 0);
        check_eq("R12 valid count", n_valid, 4);

        // R5: early chip select keeps internal timing
        write_cfg(2, 3, 4, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        do_read(32'h1FC0_0200, 4, 4, 1'b0);
        check_eq("R5 cs cycles", n_cs, 36);
        check_eq("R5 overlap", n_overlap, 8);
        check_eq("R5 oe cycles", n_oe, 16);
        check_eq("R5 busy cycles", n_busy, 37);

        // R9: multiplexed 8-bit burst steps by one byte
        write_cfg(1, 1, 2, 0, 1'b0, 1'b1, 1'b0, 1'b1);
        do_read(32'h1FC0_0300, 3, 1, 1'b1);
        check_eq("R9 narrow valid count", n_valid, 3);

        // R10: non-multiplexed burst holds the start address
        model_mux = 1'b0;
        write_cfg(1, 1, 3, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(32'h1FC0_0400, 3, 0, 1'b0);
        check_eq("R10 valid count", n_valid, 3);

        // R6 R8: fixed timing ignores ready, sample extension adds cycles
        write_cfg(1, 1, 4, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        rdy_mode = 0;
        do_read(32'h1FC0_0500, 2, 0, 1'b0);
        check_eq("R6 R8 strobe rdy low", n_oe, 12);
        rdy_mode = 1;
        do_read(32'h1FC0_0504, 2, 0, 1'b0);
        check_eq("R6 strobe rdy high", n_oe, 12);

        // R7: ready mode waits for ready, never shorter than the minimum
        write_cfg(1, 1, 4, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        rdy_mode = 2; rdy_dly = 7;
        do_read(32'h1FC0_0600, 2, 0, 1'b0);
        check_eq("R7 late ready", n_oe, 14);
        rdy_dly = 2;
        do_read(32'h1FC0_0604, 1, 0, 1'b0);
        check_eq("R7 early ready", n_oe, 4);
        write_cfg(1, 1, 4, 1, 1'b0, 1'b0, 1'b1, 1'b0);
        rdy_dly = 6;
        do_read(32'h1FC0_0608, 1, 0, 1'b0);
        check_eq("R8 extension in ready mode", n_oe, 7);

        // R2 R11: boot mode 01, 8-bit non-multiplexed, fixed
        do_reset(2'b01);
        rdy_mode = 0;
        do_read(32'h1FC0_0700, 2, 0, 1'b1);
        check_eq("R2 mode01 latch", n_ale, 8);
        check_eq("R2 mode01 strobe", n_oe, 48);

        // R2 R7: boot mode 10, ready terminated
        do_reset(2'b10);
        rdy_mode = 2; rdy_dly = 30;
        do_read(32'h1FC0_0800, 1, 0, 1'b0);
        check_eq("R2 R7 mode10 strobe", n_oe, 30);

        check_eq("R11 scoreboard empty", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule